// File: doc/BRIEF.md
# Bit Scan and Bit Test Unit

This unit performs priority scans and single-bit test operations on a word (16-bit) or doubleword (32-bit) operand. A scan searches the operand for a set bit. Searching upward from bit 0 it reports the lowest set position, and searching downward from the top bit it reports the highest set position. A zero flag marks an operand with no set bit. The bit-test operations copy one selected bit into a carry flag. They then return the operand unchanged, or with that bit forced to 1, forced to 0 or inverted.

A caller presents an operation code, the operand, a bit index and a size select, and raises `start` for one cycle. On the next clock edge the unit registers the result word, the scan index and both flags, and it raises `done` for that one cycle. Each operation changes only the outputs it defines. All other outputs keep their values, so the flags from a scan and from a later bit test can be read together.

Top module: `bsu_top`

## Requirements
- R1: Forward scan (op code 0) sets `index_out` to the position of the lowest 1 in the active operand bits and clears `zf` (operand 0x0088 gives 3).
- R2: Reverse scan (op code 1) sets `index_out` to the position of the highest 1 in the active operand bits and clears `zf` (operand 0x0088 gives 7).
- R3: A scan of an operand whose active bits are all 0 sets `zf` and leaves `index_out` at its previous value.
- R4: `size32`=0 selects a 16-bit operand and `size32`=1 selects a 32-bit operand. In 16-bit mode, operand bits 31:16 are ignored and `result` bits 31:16 are 0.
- R5: Every bit-test operation (op codes 2 to 5) sets `cf` to the original value of the selected bit. The bit index is taken modulo the operand width: bits 3:0 in 16-bit mode, bits 4:0 in 32-bit mode.
- R6: The bit-test operations return the active operand in `result` as follows. Op code 2 leaves it unchanged, op code 3 sets the selected bit, op code 4 clears it and op code 5 inverts it.
- R7: Scans return the active operand in `result` and leave `cf` unchanged. Bit-test operations leave `index_out` and `zf` unchanged.
- R8: Op codes 6 and 7 leave `result`, `index_out`, `zf` and `cf` unchanged, and `done` still pulses.
- R9: `done` is high for exactly the one cycle after a cycle with `start` high. When `start` is low, all other outputs keep their values.
- R10: Synchronous active-high `rst` clears `result`, `index_out`, `zf`, `cf` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation on the current inputs |
| op | input | 3 | Operation code: 0 forward scan, 1 reverse scan, 2 test, 3 test-and-set, 4 test-and-reset, 5 test-and-invert |
| size32 | input | 1 | 1 selects a 32-bit operand, 0 selects a 16-bit operand |
| operand | input | 32 | Source operand |
| bit_idx | input | 5 | Selected bit for bit-test operations |
| result | output | 32 | Registered operand after the operation |
| index_out | output | 5 | Registered scan position |
| zf | output | 1 | Set when the last scan found no 1 |
| cf | output | 1 | Original value of the last tested bit |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest situation to reach is an output that must hold its earlier value: an empty scan has to keep the index found by an earlier scan, and a bit test has to keep the zero flag from an earlier scan. These cases cannot be checked from a single stimulus. The vector table is therefore applied as one ordered sequence, and each expected value is computed from the state the earlier rows left behind. The sequence places an empty 16-bit scan after a 32-bit scan that found bit 31. It follows that with a bit test whose index of 16 wraps to bit 0. It then applies an unused op code after a known state.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SCAN_UP   = 3'd0,
        OP_SCAN_DOWN = 3'd1,
        OP_TEST      = 3'd2,
        OP_TEST_SET  = 3'd3,
        OP_TEST_CLR  = 3'd4,
        OP_TEST_INV  = 3'd5
    } bsu_op_e;

    typedef enum logic [1:0] {
        MOD_KEEP = 2'd0,
        MOD_SET  = 2'd1,
        MOD_CLR  = 2'd2,
        MOD_INV  = 2'd3
    } bsu_mod_e;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [IDX_W-1:0]  index;
        logic              zero;
        logic              carry;
    } bsu_state_t;

    function automatic logic [DATA_W-1:0] active_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction

    function automatic logic [IDX_W-1:0] wrap_index(input logic wide,
                                                   input logic [IDX_W-1:0] raw);
        logic [IDX_W-1:0] lim;
        lim = wide ? IDX_W'(DATA_W - 1) : IDX_W'(HALF_W - 1);
        return raw & lim;
    endfunction

    function automatic logic is_bit_op(input logic [OP_W-1:0] code);
        return (code >= OP_TEST) && (code <= OP_TEST_INV);
    endfunction

endpackage

// File: rtl/bsu_scan.sv
module bsu_scan #(
    parameter int W        = 32,
    parameter bit FROM_TOP = 1'b0
) (
    input  logic [W-1:0]         vec,
    output logic                 found,
    output logic [$clog2(W)-1:0] pos
);
    localparam int PW = $clog2(W);

    assign found = |vec;

    generate
        if (FROM_TOP) begin : g_down
            always_comb begin
                pos = '0;
                for (int i = 0; i < W; i++) begin
                    if (vec[i]) pos = PW'(i);
                end
            end
        end else begin : g_up
            always_comb begin
                pos = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (vec[i]) pos = PW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop
    import bsu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]         src,
    input  logic [$clog2(W)-1:0] sel,
    input  bsu_mod_e             mode,
    output logic                 old_bit,
    output logic [W-1:0]         dst
);
    logic [W-1:0] onehot;

    assign onehot  = {{(W-1){1'b0}}, 1'b1} << sel;
    assign old_bit = |(src & onehot);

    always_comb begin
        unique case (mode)
            MOD_SET:  dst = src | onehot;
            MOD_CLR:  dst = src & ~onehot;
            MOD_INV:  dst = src ^ onehot;
            default:  dst = src;
        endcase
    end
endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import bsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [OP_W-1:0]     op,
    input  logic                size32,
    input  logic [DATA_W-1:0]   operand,
    input  logic [IDX_W-1:0]    bit_idx,
    output logic [DATA_W-1:0]   result,
    output logic [IDX_W-1:0]    index_out,
    output logic                zf,
    output logic                cf,
    output logic                done
);
    bsu_state_t        cur, nxt;
    logic [DATA_W-1:0] act;
    logic [IDX_W-1:0]  eff_idx;
    logic              up_found, down_found;
    logic [IDX_W-1:0]  up_pos, down_pos;
    logic              bit_old;
    logic [DATA_W-1:0] bit_word;
    bsu_mod_e          mod_sel;
    logic              done_q;

    assign act     = operand & active_mask(size32);
    assign eff_idx = wrap_index(size32, bit_idx);

    bsu_scan #(.W(DATA_W), .FROM_TOP(1'b0)) u_scan_up (
        .vec   (act),
        .found (up_found),
        .pos   (up_pos)
    );

    bsu_scan #(.W(DATA_W), .FROM_TOP(1'b1)) u_scan_down (
        .vec   (act),
        .found (down_found),
        .pos   (down_pos)
    );

    always_comb begin
        unique case (op)
            OP_TEST_SET: mod_sel = MOD_SET;
            OP_TEST_CLR: mod_sel = MOD_CLR;
            OP_TEST_INV: mod_sel = MOD_INV;
            default:     mod_sel = MOD_KEEP;
        endcase
    end

    bsu_bitop #(.W(DATA_W)) u_bitop (
        .src     (act),
        .sel     (eff_idx),
        .mode    (mod_sel),
        .old_bit (bit_old),
        .dst     (bit_word)
    );

    always_comb begin
        nxt = cur;
        if (op == OP_SCAN_UP) begin
            nxt.word = act;
            nxt.zero = !up_found;
            if (up_found) nxt.index = up_pos;
        end else if (op == OP_SCAN_DOWN) begin
            nxt.word = act;
            nxt.zero = !down_found;
            if (down_found) nxt.index = down_pos;
        end else if (is_bit_op(op)) begin
            nxt.word  = bit_word;
            nxt.carry = bit_old;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) cur <= nxt;
        end
    end

    assign result    = cur.word;
    assign index_out = cur.index;
    assign zf        = cur.zero;
    assign cf        = cur.carry;
    assign done      = done_q;
endmodule

// File: rtl/bsu_chk.sv
module bsu_chk
    import bsu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [OP_W-1:0]     op,
    input logic                size32,
    input logic [DATA_W-1:0]   operand,
    input logic [IDX_W-1:0]    bit_idx,
    input logic [DATA_W-1:0]   result,
    input logic [IDX_W-1:0]    index_out,
    input logic                zf,
    input logic                cf,
    input logic                done
);
    logic [DATA_W-1:0] act_c;
    logic [IDX_W-1:0]  sel_c;
    logic [DATA_W-1:0] below_mask;
    logic [DATA_W-1:0] above_mask;

    assign act_c      = operand & active_mask(size32);
    assign sel_c      = wrap_index(size32, bit_idx);
    assign below_mask = (DATA_W'(1) << index_out) - DATA_W'(1);
    assign above_mask = ~((DATA_W'(1) << index_out) | below_mask);

    // R9: done follows start by one cycle
    a_r9_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(index_out) && $stable(zf) && $stable(cf)));

    // R1: forward scan hit is the lowest set bit
    a_r1_forward_lowest: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_SCAN_UP && act_c != '0) |=>
        (!zf && ((result >> index_out) & DATA_W'(1)) == DATA_W'(1) && (result & below_mask) == '0));

    // R2: reverse scan hit is the highest set bit
    a_r2_reverse_highest: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_SCAN_DOWN && act_c != '0) |=>
        (!zf && ((result >> index_out) & DATA_W'(1)) == DATA_W'(1) && (result & above_mask) == '0));

    // R3: empty scan sets zf and holds the index
    a_r3_empty_scan: assert property (@(posedge clk) disable iff (rst)
        (start && op <= OP_SCAN_DOWN && act_c == '0) |=> (zf && $stable(index_out)));

    // R5: carry takes the original selected bit
    a_r5_carry_old_bit: assert property (@(posedge clk) disable iff (rst)
        (start && is_bit_op(op)) |=> (cf == $past(act_c[sel_c])));

    // R7: bit tests keep index and zero flag, scans keep carry
    a_r7_bitop_keeps_scan: assert property (@(posedge clk) disable iff (rst)
        (start && is_bit_op(op)) |=> ($stable(index_out) && $stable(zf)));
    a_r7_scan_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (start && op <= OP_SCAN_DOWN) |=> $stable(cf));

    // R8: unused codes change nothing
    a_r8_unused_code: assert property (@(posedge clk) disable iff (rst)
        (start && op > OP_TEST_INV) |=> ($stable(result) && $stable(index_out) && $stable(zf) && $stable(cf)));

    // R4: upper half of result is zero in 16-bit mode
    a_r4_narrow_result: assert property (@(posedge clk) disable iff (rst)
        (start && !size32 && op <= OP_TEST_INV) |=> (result[DATA_W-1:HALF_W] == '0));
endmodule

bind bsu_top bsu_chk u_bsu_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .size32    (size32),
    .operand   (operand),
    .bit_idx   (bit_idx),
    .result    (result),
    .index_out (index_out),
    .zf        (zf),
    .cf        (cf),
    .done      (done)
);

// File: tb/tb_bsu_top.sv
module tb_bsu_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic [31:0] opnd;
        logic [4:0]  idx;
        logic [31:0] e_res;
        logic [4:0]  e_index;
        logic        e_zf;
        logic        e_cf;
    } vec_t;

    localparam int NV = 18;
    // Ordered sequence: expectations carry state left by earlier rows.
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 32'h0000_0088, 5'd0,  32'h0000_0088, 5'd3,  1'b0, 1'b0}, // R1
        '{3'd1, 1'b0, 32'h0000_0088, 5'd0,  32'h0000_0088, 5'd7,  1'b0, 1'b0}, // R2
        '{3'd2, 1'b0, 32'h0000_0088, 5'd3,  32'h0000_0088, 5'd7,  1'b0, 1'b1}, // R5 R6 R7
        '{3'd3, 1'b0, 32'h0000_0088, 5'd0,  32'h0000_0089, 5'd7,  1'b0, 1'b0}, // R6
        '{3'd4, 1'b0, 32'h0000_0089, 5'd7,  32'h0000_0009, 5'd7,  1'b0, 1'b1}, // R6
        '{3'd5, 1'b0, 32'h0000_0009, 5'd1,  32'h0000_000B, 5'd7,  1'b0, 1'b0}, // R6
        '{3'd0, 1'b1, 32'h8000_0000, 5'd0,  32'h8000_0000, 5'd31, 1'b0, 1'b0}, // R1 R4
        '{3'd0, 1'b1, 32'h8000_0001, 5'd0,  32'h8000_0001, 5'd0,  1'b0, 1'b0}, // R1
        '{3'd1, 1'b1, 32'h8000_0001, 5'd0,  32'h8000_0001, 5'd31, 1'b0, 1'b0}, // R2
        '{3'd0, 1'b1, 32'h0000_0000, 5'd0,  32'h0000_0000, 5'd31, 1'b1, 1'b0}, // R3
        '{3'd1, 1'b0, 32'hABCD_0000, 5'd0,  32'h0000_0000, 5'd31, 1'b1, 1'b0}, // R3 R4
        '{3'd0, 1'b0, 32'hFFFF_8000, 5'd0,  32'h0000_8000, 5'd15, 1'b0, 1'b0}, // R1 R4
        '{3'd5, 1'b0, 32'h1234_0001, 5'd16, 32'h0000_0000, 5'd15, 1'b0, 1'b1}, // R5 wrap
        '{3'd3, 1'b1, 32'h0000_0000, 5'd31, 32'h8000_0000, 5'd15, 1'b0, 1'b0}, // R6
        '{3'd2, 1'b1, 32'hFFFF_FFFE, 5'd0,  32'hFFFF_FFFE, 5'd15, 1'b0, 1'b0}, // R5
        '{3'd6, 1'b1, 32'h0000_1234, 5'd3,  32'hFFFF_FFFE, 5'd15, 1'b0, 1'b0}, // R8
        '{3'd1, 1'b1, 32'h0000_0100, 5'd0,  32'h0000_0100, 5'd8,  1'b0, 1'b0}, // R2 R7
        '{3'd4, 1'b1, 32'hFFFF_FFFF, 5'd20, 32'hFFEF_FFFF, 5'd8,  1'b0, 1'b1}  // R6
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic        size32;
    logic [31:0] operand;
    logic [4:0]  bit_idx;
    logic [31:0] result;
    logic [4:0]  index_out;
    logic        zf, cf, done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    bsu_top dut (
        .clk (clk), .rst (rst), .start (start), .op (op), .size32 (size32),
        .operand (operand), .bit_idx (bit_idx), .result (result),
        .index_out (index_out), .zf (zf), .cf (cf), .done (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic w, input logic [31:0] d,
                         input logic [4:0] i);
        @(negedge clk);
        op = o; size32 = w; operand = d; bit_idx = i; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; size32 = 1'b0; operand = '0; bit_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 result", result, 32'h0);
        check("R10 index", {27'h0, index_out}, 32'h0);
        check("R10 flags/done", {29'h0, zf, cf, done}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].op, VECS[k].wide, VECS[k].opnd, VECS[k].idx);
            check($sformatf("R9 done row %0d", k), {31'h0, done}, 32'h1);
            check($sformatf("R1-R8 result row %0d", k), result, VECS[k].e_res);
            check($sformatf("R3 index row %0d", k), {27'h0, index_out}, {27'h0, VECS[k].e_index});
            check($sformatf("R3 zf row %0d", k), {31'h0, zf}, {31'h0, VECS[k].e_zf});
            check($sformatf("R5 cf row %0d", k), {31'h0, cf}, {31'h0, VECS[k].e_cf});
        end

        // R9: done drops after one cycle, outputs hold while idle
        @(negedge clk);
        check("R9 done single pulse", {31'h0, done}, 32'h0);
        op = 3'd3; size32 = 1'b1; operand = 32'h0; bit_idx = 5'd0;
        repeat (3) @(negedge clk);
        check("R9 idle result hold", result, 32'hFFEF_FFFF);
        check("R9 idle index hold", {27'h0, index_out}, 32'd8);
        check("R9 idle cf hold", {31'h0, cf}, 32'h1);
        check("R9 idle done low", {31'h0, done}, 32'h0);

        // R8: code 7 after a known state
        issue(3'd7, 1'b0, 32'h0000_0000, 5'd0);
        check("R8 code7 result", result, 32'hFFEF_FFFF);
        check("R8 code7 flags", {30'h0, zf, cf}, 32'h1);
        check("R8 code7 done", {31'h0, done}, 32'h1);

        // R10: reset clears a non-zero state
        issue(3'd0, 1'b1, 32'h0000_0000, 5'd0);
        check("R3 zf before reset", {31'h0, zf}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset result", result, 32'h0);
        check("R10 reset index", {27'h0, index_out}, 32'h0);
        check("R10 reset flags", {29'h0, zf, cf, done}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule